// File: doc/BRIEF.md
# Bank-Parallel Sparse Row Dot-Product Engine

The engine forms the dot product of one sparse matrix row, pruned so that every bank of the row keeps the same number of nonzeros, with a dense vector held on chip. The vector is split into `NUM_BANKS` equal slices. Each slice sits in its own small memory, which is filled through a shared write port while the engine is idle. A row arrives as a run of beats. Each beat carries one signed value per bank and, for each bank, the index of the matching vector element inside that bank.

Each lane uses its index unchanged as the read address of its own bank memory. Every bank is therefore read exactly once per beat, and two lanes never compete for one memory. The lane products of a beat are formed in parallel and summed by a binary adder tree. The tree sums of a row's beats are added into a wide accumulator that has guard bits. After the beat flagged last has drained, the total is shifted right by a fixed-point shift and clamped to the operand width, and the result appears with a one-cycle valid pulse.

Top module: `sdp_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `res_valid` and `res_data` are 0. A row in flight when reset is asserted produces no result.
- R2: Lane i (value bits [16i+15:16i], index bits [3i+2:3i]) multiplies its value by the word stored in vector bank i at the address given by its index. It never reads any other bank.
- R3: The row result is the sum over all beats and lanes of value times vector word, arithmetically shifted right by `FRAC_SHIFT` (default 4). Operands and result are 16-bit two's complement.
- R4: `res_valid` is high for exactly one cycle per row. It rises on the second rising edge after the edge that accepts the beat with `beat_last` set.
- R5: The accumulator restarts at zero with the first beat of each row, so rows issued back to back with no idle cycle between them give independent results.
- R6: `busy` is high in the cycle after any beat is accepted. It stays high until the row's last beat has left the pipeline, and it is low in the cycle the result is presented when no new row has started.
- R7: A vector write (`wr_en`) takes effect only when `busy` and `beat_valid` are both low. A write attempted while a row is in flight leaves the bank word unchanged.
- R8: A shifted total above 32767 is output as 32767, and one below -32768 is output as -32768.
- R9: Idle cycles (`beat_valid` low) between the beats of a row do not change the row's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Vector bank write request |
| wr_bank | input | 2 | Bank selected by the write |
| wr_addr | input | 3 | Word address inside the selected bank |
| wr_data | input | 16 | Signed vector word to store |
| beat_valid | input | 1 | A beat is presented this cycle |
| beat_last | input | 1 | The presented beat ends its row |
| beat_vals | input | 64 | One signed matrix value per lane, lane i at [16i+15:16i] |
| beat_idx | input | 12 | One bank-internal index per lane, lane i at [3i+2:3i] |
| busy | output | 1 | A row is open or beats remain in the pipeline |
| res_valid | output | 1 | One-cycle pulse marking a new row result |
| res_data | output | 16 | Saturated row result, held until the next pulse |

## Verification
A beat presented in cycle c is captured at the edge that ends c. The bank read and the tree sum each add one register, and the accumulator adds one more, so a row's result is due in cycle c+3, where c is the cycle of its last beat. When the bench drives a last beat it records c+3 next to the expected value. A monitor that samples on the falling edge accepts a `res_valid` pulse only in that exact cycle, and it treats a pulse with no pending row as a failure. Checks on `busy` and on the reset state are also sampled on falling edges: one cycle after a beat is accepted, and in the cycle the result is presented.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int SDP_DATA_W  = 16;
    localparam int SDP_BANKS   = 4;
    localparam int SDP_DEPTH   = 8;
    localparam int SDP_GUARD_W = 4;
    localparam int SDP_FRAC    = 4;

    // control that travels beside the datapath through every stage
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } sdp_ctl_t;

    localparam sdp_ctl_t SDP_CTL_IDLE = '{valid: 1'b0, first: 1'b0, last: 1'b0};

endpackage

// File: rtl/sdp_vec_bank.sv
module sdp_vec_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem_q[rd_addr];
        end
    end

endmodule

// File: rtl/sdp_lane_tree.sv
module sdp_lane_tree
    import sdp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 4,
    localparam int LOG_L = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int SUM_W = 2 * DATA_W + LOG_L,
    localparam int NODES = 2 * LANES - 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  sdp_ctl_t                 in_ctl,
    input  logic [LANES*DATA_W-1:0]  in_vals,
    input  logic [LANES*DATA_W-1:0]  in_vec,
    output sdp_ctl_t                 out_ctl,
    output logic signed [SUM_W-1:0]  out_sum
);

    // heap-ordered tree: node k has children 2k+1 and 2k+2, leaves at LANES-1..
    logic signed [SUM_W-1:0] node [NODES];

    for (genvar i = 0; i < LANES; i++) begin : g_leaf
        logic signed [DATA_W-1:0]   a_s;
        logic signed [DATA_W-1:0]   b_s;
        logic signed [2*DATA_W-1:0] prod;
        assign a_s  = in_vals[i*DATA_W +: DATA_W];
        assign b_s  = in_vec[i*DATA_W +: DATA_W];
        assign prod = a_s * b_s;
        assign node[LANES-1+i] = SUM_W'(prod);
    end

    for (genvar k = 0; k < LANES - 1; k++) begin : g_node
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_ctl <= SDP_CTL_IDLE;
            out_sum <= '0;
        end else begin
            out_ctl <= in_ctl;
            if (in_ctl.valid) begin
                out_sum <= node[0];
            end
        end
    end

endmodule

// File: rtl/sdp_accum.sv
module sdp_accum
    import sdp_pkg::*;
#(
    parameter int SUM_W      = 34,
    parameter int GUARD_W    = 4,
    parameter int DATA_W     = 16,
    parameter int FRAC_SHIFT = 4,
    localparam int ACC_W     = SUM_W + GUARD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  sdp_ctl_t                in_ctl,
    input  logic signed [SUM_W-1:0] in_sum,
    output logic                    res_valid,
    output logic [DATA_W-1:0]       res_data
);

    localparam logic signed [ACC_W-1:0] MAX_V =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V = ~MAX_V;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_nxt;
    logic signed [ACC_W-1:0] scaled;
    logic [DATA_W-1:0]       clamped;

    always_comb begin
        acc_nxt = (in_ctl.first ? '0 : acc_q) + ACC_W'(in_sum);
        scaled  = acc_nxt >>> FRAC_SHIFT;
        if (scaled > MAX_V) begin
            clamped = MAX_V[DATA_W-1:0];
        end else if (scaled < MIN_V) begin
            clamped = MIN_V[DATA_W-1:0];
        end else begin
            clamped = scaled[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= in_ctl.valid && in_ctl.last;
            if (in_ctl.valid) begin
                acc_q <= acc_nxt;
                if (in_ctl.last) begin
                    res_data <= clamped;
                end
            end
        end
    end

endmodule

// File: rtl/sdp_engine.sv
module sdp_engine
    import sdp_pkg::*;
#(
    parameter int DATA_W     = SDP_DATA_W,
    parameter int NUM_BANKS  = SDP_BANKS,
    parameter int BANK_DEPTH = SDP_DEPTH,
    parameter int GUARD_W    = SDP_GUARD_W,
    parameter int FRAC_SHIFT = SDP_FRAC,
    localparam int AW        = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1,
    localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int LOG_B     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int SUM_W     = 2 * DATA_W + LOG_B
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [BSEL_W-1:0]           wr_bank,
    input  logic [AW-1:0]               wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        beat_valid,
    input  logic                        beat_last,
    input  logic [NUM_BANKS*DATA_W-1:0] beat_vals,
    input  logic [NUM_BANKS*AW-1:0]     beat_idx,
    output logic                        busy,
    output logic                        res_valid,
    output logic [DATA_W-1:0]           res_data
);

    logic                        row_open_q;
    sdp_ctl_t                    in_ctl;
    sdp_ctl_t                    s1_ctl_q;
    logic [NUM_BANKS*DATA_W-1:0] s1_vals_q;
    logic [NUM_BANKS*DATA_W-1:0] s1_vec;
    sdp_ctl_t                    s2_ctl;
    logic signed [SUM_W-1:0]     s2_sum;
    logic                        wr_ok;

    assign in_ctl = '{valid: beat_valid, first: beat_valid && !row_open_q, last: beat_last};
    assign busy   = row_open_q || s1_ctl_q.valid || s2_ctl.valid;
    assign wr_ok  = wr_en && !busy && !beat_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open_q <= 1'b0;
            s1_ctl_q   <= SDP_CTL_IDLE;
            s1_vals_q  <= '0;
        end else begin
            s1_ctl_q <= in_ctl;
            if (beat_valid) begin
                row_open_q <= !beat_last;
                s1_vals_q  <= beat_vals;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdp_vec_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (BANK_DEPTH)
        ) bank_i (
            .clk     (clk),
            .wr_en   (wr_ok && (wr_bank == BSEL_W'(b))),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_en   (beat_valid),
            .rd_addr (beat_idx[b*AW +: AW]),
            .rd_data (s1_vec[b*DATA_W +: DATA_W])
        );
    end

    sdp_lane_tree #(
        .DATA_W (DATA_W),
        .LANES  (NUM_BANKS)
    ) tree_i (
        .clk     (clk),
        .rst     (rst),
        .in_ctl  (s1_ctl_q),
        .in_vals (s1_vals_q),
        .in_vec  (s1_vec),
        .out_ctl (s2_ctl),
        .out_sum (s2_sum)
    );

    sdp_accum #(
        .SUM_W      (SUM_W),
        .GUARD_W    (GUARD_W),
        .DATA_W     (DATA_W),
        .FRAC_SHIFT (FRAC_SHIFT)
    ) acc_i (
        .clk       (clk),
        .rst       (rst),
        .in_ctl    (s2_ctl),
        .in_sum    (s2_sum),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

endmodule

// File: rtl/sdp_engine_chk.sv
module sdp_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              beat_valid,
    input logic              beat_last,
    input logic              busy,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data
);

    AST_RESULT_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(beat_valid && beat_last, 3)) else $error("result without last beat"); // R4

    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !beat_valid) |=> !res_valid) else $error("result from empty pipeline"); // R4

    AST_BEAT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        beat_valid |=> busy) else $error("busy low after beat"); // R6

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_data)) else $error("result changed without pulse"); // R3

endmodule

bind sdp_engine sdp_engine_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_data   (res_data)
);

// File: tb/sdp_engine_tb_top.sv
module sdp_engine_tb_top;

    localparam int B  = 4;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int EW = 1 + B*AW + B*DW;
    localparam int NV = 10;

    // {last, idx3, idx2, idx1, idx0, val3, val2, val1, val0}
    localparam logic [EW-1:0] TBL [NV] = '{
        {1'b0, 3'd1, 3'd3, 3'd0, 3'd2, 16'h0064, 16'h00C8, 16'hFF38, 16'h012C},
        {1'b1, 3'd5, 3'd4, 3'd2, 3'd0, 16'h0032, 16'hFFCE, 16'h0096, 16'h000A},
        {1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
        {1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
        {1'b0, 3'd6, 3'd6, 3'd6, 3'd6, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
        {1'b1, 3'd6, 3'd6, 3'd6, 3'd6, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
        {1'b0, 3'd3, 3'd2, 3'd1, 3'd0, 16'h0010, 16'h0020, 16'h0030, 16'h0040},
        {1'b1, 3'd5, 3'd5, 3'd5, 3'd5, 16'hFFF0, 16'h0011, 16'hFFE0, 16'h0021},
        {1'b0, 3'd2, 3'd4, 3'd1, 3'd3, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {1'b1, 3'd0, 3'd5, 3'd3, 3'd1, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_bank = '0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              beat_valid = 1'b0;
    logic              beat_last = 1'b0;
    logic [B*DW-1:0]   beat_vals = '0;
    logic [B*AW-1:0]   beat_idx = '0;
    logic              busy;
    logic              res_valid;
    logic [DW-1:0]     res_data;

    int     cyc = 0;
    int     checks = 0, fails = 0;
    int     mon_checks = 0, mon_fails = 0;
    int     exp_q [64];
    int     due_q [64];
    string  tag_q [64];
    int     q_wr = 0, q_rd = 0;
    int     vmem [B][8];
    longint acc_m = 0;
    bit     done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sdp_engine dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(wr_data), .beat_valid(beat_valid), .beat_last(beat_last),
        .beat_vals(beat_vals), .beat_idx(beat_idx), .busy(busy),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic int sat_shift(longint s);
        longint t = s >>> 4;
        if (t > 32767) return 32767;
        if (t < -32768) return -32768;
        return int'(t);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; beat_valid = 1'b0; beat_last = 1'b0;
        beat_vals = '0; beat_idx = '0;
    endtask

    task automatic write_word(int b, int a, int d);
        @(negedge clk);
        beat_valid = 1'b0;
        wr_en = 1'b1; wr_bank = 2'(b); wr_addr = 3'(a); wr_data = 16'(d);
    endtask

    task automatic beat(logic [EW-1:0] e, string tag);
        @(negedge clk);
        wr_en = 1'b0;
        beat_valid = 1'b1;
        beat_last = e[EW-1];
        beat_idx  = e[B*DW +: B*AW];
        beat_vals = e[B*DW-1:0];
        for (int i = 0; i < B; i++) begin
            acc_m += longint'($signed(e[i*DW +: DW])) * longint'(vmem[i][e[B*DW + i*AW +: AW]]);
        end
        if (e[EW-1]) begin
            exp_q[q_wr] = sat_shift(acc_m);
            due_q[q_wr] = cyc + 3;
            tag_q[q_wr] = tag;
            q_wr++;
            acc_m = 0;
        end
    endtask

    // result monitor: value and exact cycle of every pulse
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            mon_checks++;
            if (q_rd >= q_wr) begin
                mon_fails++;
                $display("FAIL R4: actual unexpected result %0d expected no pulse", $signed(res_data));
            end else begin
                if ($signed(res_data) != exp_q[q_rd]) begin
                    mon_fails++;
                    $display("FAIL %s: actual %0d expected %0d", tag_q[q_rd], $signed(res_data), exp_q[q_rd]);
                end
                if (cyc != due_q[q_rd]) begin
                    mon_fails++;
                    $display("FAIL R4: actual cycle %0d expected cycle %0d", cyc, due_q[q_rd]);
                end
                q_rd++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < B; b++) begin
            for (int a = 0; a < 8; a++) begin
                vmem[b][a] = (a < 6) ? (b*8 + a)*5 - 30 : ((a == 6) ? -32768 : 32767);
            end
        end
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && res_valid == 1'b0 && res_data == '0, "R1 in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && res_valid == 1'b0 && res_data == '0, "R1 after reset", int'(res_data), 0);

        for (int b = 0; b < B; b++) begin
            for (int a = 0; a < 8; a++) begin
                write_word(b, a, vmem[b][a]);
            end
        end
        idle();

        // table walk: rows back to back (R3, R5, R8)
        for (int k = 0; k < NV; k++) begin
            beat(TBL[k], "R3/R5/R8 table row");
        end
        idle();
        repeat (6) @(negedge clk);

        // R2: only lane 2 active, index 3 -> word of bank 2 address 3
        beat({1'b1, 3'd0, 3'd3, 3'd0, 3'd0, 16'h0000, 16'h0010, 16'h0000, 16'h0000}, "R2 lane bank select");
        idle();
        repeat (5) @(negedge clk);

        // R6 and R7: writes during a row are dropped
        beat({1'b0, 12'h000, 64'h0}, "R7 row");
        @(negedge clk);
        check(busy == 1'b1, "R6 busy after beat", int'(busy), 1);
        beat_valid = 1'b0;
        wr_en = 1'b1; wr_bank = 2'd0; wr_addr = 3'd0; wr_data = 16'd1000;
        beat({1'b1, 12'h000, 64'h0}, "R7 row");
        wr_en = 1'b1; wr_bank = 2'd0; wr_addr = 3'd0; wr_data = 16'd2000;
        idle();
        @(negedge clk);
        @(negedge clk);
        check(res_valid == 1'b1 && busy == 1'b0, "R6 busy low at result", int'(busy), 0);
        idle();
        beat({1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0010}, "R7 word unchanged");
        idle();
        repeat (5) @(negedge clk);

        // R9: idle cycles inside a row
        beat(TBL[0], "R9 gap row");
        idle();
        idle();
        beat(TBL[1], "R9 gap row");
        idle();
        repeat (5) @(negedge clk);

        // R1: reset mid-row discards the row
        beat({1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 64'h0040_0040_0040_0040}, "R1 abort");
        acc_m = 0;
        @(negedge clk);
        beat_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && res_valid == 1'b0, "R1 reset mid-row", int'(busy), 0);
        repeat (6) @(negedge clk);

        check(q_rd == q_wr, "R4 all results seen", q_rd, q_wr);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule